// File: doc/BRIEF.md
# DMA Channel Address and Trigger Controller

This block is the per-channel control core of a small DMA engine. Software programs a set of shadow address values, a signed per-word step, a signed wrap step and a wrap length through a simple register-write port. The hardware keeps its own active begin-address and address pointers. It loads them from the shadows when a transfer starts and advances them as words complete. It also moves them to a new window whenever the wrap count runs out, and it rewinds them when a sync error is reported. Each shadow feeds only its own active counterpart. The active pointers never change through a software write.

The same block turns peripheral event triggers into a pending request. An external channel state machine consumes that request with a burst-start strobe. A trigger that arrives while a request is still waiting is lost, and the block records this as a sticky overrun flag. When overrun reporting is enabled, it also pulses the channel interrupt. A halt output gathers three stop conditions, and while it is high the active pointers are frozen so that the transfer resumes where it stopped.

Top module: `dma_ch_ctrl`

## Requirements
- R1: After reset, addr_o, beg_addr_o, pend_o, ovf_o and irq_o are 0. With all halt inputs low, halted_o is 0.
- R2: A transfer start (xfer_start_i) copies shadow begin (select 0) into beg_addr_o and shadow address (select 1) into addr_o at the next edge. It also loads the wrap counter from the wrap length (select 4). The shadows are not altered, so a later start reloads the same values.
- R3: Each word_done_i adds the signed word step (select 2, two's complement) to addr_o and decrements the wrap counter, provided the counter is not 0.
- R4: A word_done_i that finds the wrap counter at 0 is a wrap. It adds the signed wrap step (select 3) to beg_addr_o, sets addr_o to that new begin value, and reloads the counter.
- R5: A sync error (sync_err_i) sets addr_o to beg_addr_o, leaves beg_addr_o unchanged and reloads the wrap counter.
- R6: A register write never changes addr_o or beg_addr_o directly.
- R7: A trigger sets pend_o, and burst_start_i without a trigger clears it.
- R8: A trigger while pend_o is 1 and burst_start_i is 0 sets ovf_o, and ovf_o stays set. pend_o stays 1.
- R9: A trigger and burst_start_i in the same cycle while pend_o is 1 leave pend_o at 1 and do not set ovf_o.
- R10: A write to select 5 with bit 2 set clears ovf_o, unless an overrun occurs in the same cycle.
- R11: irq_o is high for the cycle after each overrun event if control bit 0 (select 5) is 1, and is never high while that bit is 0.
- R12: halted_o = ch1_hi_trig_i | halt_cmd_i | (dbg_halt_i & ~free-run), where free-run is control bit 1. While halted_o is 1, addr_o and beg_addr_o hold, and stepping continues from the same values after the halt.
- R13: Address events take priority in this order: start, then sync error, then word done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select (0 shadow begin, 1 shadow address, 2 word step, 3 wrap step, 4 wrap length, 5 control) |
| reg_wdata_i | input | AW | Write data |
| trig_i | input | 1 | Peripheral event trigger |
| burst_start_i | input | 1 | Burst start from the channel state machine |
| xfer_start_i | input | 1 | Transfer start |
| word_done_i | input | 1 | One word completed |
| sync_err_i | input | 1 | Sync error |
| ch1_hi_trig_i | input | 1 | Higher-priority channel-1 trigger |
| halt_cmd_i | input | 1 | Software halt command |
| dbg_halt_i | input | 1 | Debug halt request |
| addr_o | output | AW | Active address |
| beg_addr_o | output | AW | Active begin address |
| pend_o | output | 1 | Pending request flag |
| ovf_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Channel interrupt pulse |
| halted_o | output | 1 | Channel is at its halt point |

## Verification
The address path is driven in three ways. Positive and negative word steps test the signed addition. A run long enough to exhaust the wrap count separates a wrap from a plain step. Start, sync error and word done are applied in the same cycle to expose the priority. The trigger path is driven with isolated triggers, back-to-back triggers and trigger-with-burst coincidences. These separate a set, a lost trigger and a same-cycle consume-and-refill. Each halt source is applied together with word strobes, once with free-run off and once with it on, to show which sources freeze the pointers.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;
  typedef enum logic [2:0] {
    SEL_SH_BEG   = 3'd0,
    SEL_SH_ADDR  = 3'd1,
    SEL_WSTEP    = 3'd2,
    SEL_WRSTEP   = 3'd3,
    SEL_WRLEN    = 3'd4,
    SEL_CTRL     = 3'd5
  } reg_sel_e;

  localparam int CTRL_IRQ_EN_BIT = 0;
  localparam int CTRL_FREE_BIT   = 1;
  localparam int CTRL_CLR_BIT    = 2;
endpackage

// File: rtl/dma_ch_regs.sv
module dma_ch_regs
  import dma_ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    sel_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] sh_beg_o,
  output logic [AW-1:0] sh_addr_o,
  output logic [AW-1:0] word_step_o,
  output logic [AW-1:0] wrap_step_o,
  output logic [CW-1:0] wrap_len_o,
  output logic          irq_en_o,
  output logic          free_run_o,
  output logic          ovf_clr_o
);
  logic [AW-1:0] sh_beg_q, sh_addr_q, wstep_q, wrstep_q;
  logic [CW-1:0] wrlen_q;
  logic          irq_en_q, free_q;
  logic          hit_ctrl;

  assign hit_ctrl = we_i && (sel_i == SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_beg_q  <= '0;
      sh_addr_q <= '0;
      wstep_q   <= '0;
      wrstep_q  <= '0;
      wrlen_q   <= '0;
      irq_en_q  <= 1'b0;
      free_q    <= 1'b0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_SH_BEG:  sh_beg_q  <= wdata_i;
        SEL_SH_ADDR: sh_addr_q <= wdata_i;
        SEL_WSTEP:   wstep_q   <= wdata_i;
        SEL_WRSTEP:  wrstep_q  <= wdata_i;
        SEL_WRLEN:   wrlen_q   <= wdata_i[CW-1:0];
        SEL_CTRL: begin
          irq_en_q <= wdata_i[CTRL_IRQ_EN_BIT];
          free_q   <= wdata_i[CTRL_FREE_BIT];
        end
        default: ;
      endcase
    end
  end

  assign sh_beg_o    = sh_beg_q;
  assign sh_addr_o   = sh_addr_q;
  assign word_step_o = wstep_q;
  assign wrap_step_o = wrstep_q;
  assign wrap_len_o  = wrlen_q;
  assign irq_en_o    = irq_en_q;
  assign free_run_o  = free_q;
  assign ovf_clr_o   = hit_ctrl && wdata_i[CTRL_CLR_BIT];
endmodule

// File: rtl/dma_ch_addr.sv
module dma_ch_addr #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          start_i,
  input  logic          sync_err_i,
  input  logic          word_i,
  input  logic [AW-1:0] sh_beg_i,
  input  logic [AW-1:0] sh_addr_i,
  input  logic [AW-1:0] word_step_i,
  input  logic [AW-1:0] wrap_step_i,
  input  logic [CW-1:0] wrap_len_i,
  output logic [AW-1:0] beg_o,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] beg_q, addr_q, beg_wrap;
  logic [CW-1:0] cnt_q;
  logic          wrap_now;

  // two's complement add covers negative steps
  assign beg_wrap = beg_q + wrap_step_i;
  assign wrap_now = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beg_q  <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (!hold_i) begin
      if (start_i) begin
        beg_q  <= sh_beg_i;
        addr_q <= sh_addr_i;
        cnt_q  <= wrap_len_i;
      end else if (sync_err_i) begin
        addr_q <= beg_q;
        cnt_q  <= wrap_len_i;
      end else if (word_i) begin
        if (wrap_now) begin
          beg_q  <= beg_wrap;
          addr_q <= beg_wrap;
          cnt_q  <= wrap_len_i;
        end else begin
          addr_q <= addr_q + word_step_i;
          cnt_q  <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign beg_o  = beg_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/dma_ch_trig.sv
module dma_ch_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic burst_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic pend_o,
  output logic ovf_o,
  output logic irq_o
);
  logic pend_q, ovf_q, irq_q, lost;

  // dropped trigger: still pending and not consumed this cycle
  assign lost = trig_i && pend_q && !burst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (trig_i)       pend_q <= 1'b1;
      else if (burst_i) pend_q <= 1'b0;
      if (lost)         ovf_q <= 1'b1;
      else if (clr_i)   ovf_q <= 1'b0;
      irq_q <= lost && irq_en_i;
    end
  end

  assign pend_o = pend_q;
  assign ovf_o  = ovf_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/dma_ch_ctrl.sv
module dma_ch_ctrl #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_sel_i,
  input  logic [AW-1:0] reg_wdata_i,
  input  logic          trig_i,
  input  logic          burst_start_i,
  input  logic          xfer_start_i,
  input  logic          word_done_i,
  input  logic          sync_err_i,
  input  logic          ch1_hi_trig_i,
  input  logic          halt_cmd_i,
  input  logic          dbg_halt_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] beg_addr_o,
  output logic          pend_o,
  output logic          ovf_o,
  output logic          irq_o,
  output logic          halted_o
);
  logic [AW-1:0] sh_beg, sh_addr, word_step, wrap_step;
  logic [CW-1:0] wrap_len;
  logic          irq_en, free_run, ovf_clr;

  dma_ch_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .sel_i       (reg_sel_i),
    .wdata_i     (reg_wdata_i),
    .sh_beg_o    (sh_beg),
    .sh_addr_o   (sh_addr),
    .word_step_o (word_step),
    .wrap_step_o (wrap_step),
    .wrap_len_o  (wrap_len),
    .irq_en_o    (irq_en),
    .free_run_o  (free_run),
    .ovf_clr_o   (ovf_clr)
  );

  assign halted_o = ch1_hi_trig_i || halt_cmd_i || (dbg_halt_i && !free_run);

  dma_ch_addr #(.AW(AW), .CW(CW)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_i      (halted_o),
    .start_i     (xfer_start_i),
    .sync_err_i  (sync_err_i),
    .word_i      (word_done_i),
    .sh_beg_i    (sh_beg),
    .sh_addr_i   (sh_addr),
    .word_step_i (word_step),
    .wrap_step_i (wrap_step),
    .wrap_len_i  (wrap_len),
    .beg_o       (beg_addr_o),
    .addr_o      (addr_o)
  );

  dma_ch_trig u_trig (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (trig_i),
    .burst_i  (burst_start_i),
    .clr_i    (ovf_clr),
    .irq_en_i (irq_en),
    .pend_o   (pend_o),
    .ovf_o    (ovf_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/dma_ch_ctrl_chk.sv
module dma_ch_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          xfer_start_i,
  input logic          sync_err_i,
  input logic          trig_i,
  input logic          burst_start_i,
  input logic          halted_o,
  input logic [AW-1:0] addr_o,
  input logic [AW-1:0] beg_addr_o,
  input logic          pend_o,
  input logic          ovf_o,
  input logic          irq_o,
  input logic [AW-1:0] sh_beg,
  input logic [AW-1:0] sh_addr,
  input logic          irq_en
);
  AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_start_i && !halted_o) |=> (addr_o == $past(sh_addr) && beg_addr_o == $past(sh_beg))); // R2
  AST_SYNC_REWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_err_i && !xfer_start_i && !halted_o) |=> (addr_o == $past(beg_addr_o) && $stable(beg_addr_o))); // R5
  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> ($stable(addr_o) && $stable(beg_addr_o))); // R12
  AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_start_i && !trig_i) |=> !pend_o); // R7
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && pend_o && !burst_start_i) |=> (ovf_o && pend_o)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_o && !(trig_i && pend_o && !burst_start_i)) |=> !ovf_o); // R9
  AST_IRQ_WITH_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ovf_o); // R11
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en |=> !irq_o); // R11
endmodule

bind dma_ch_ctrl dma_ch_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .xfer_start_i  (xfer_start_i),
  .sync_err_i    (sync_err_i),
  .trig_i        (trig_i),
  .burst_start_i (burst_start_i),
  .halted_o      (halted_o),
  .addr_o        (addr_o),
  .beg_addr_o    (beg_addr_o),
  .pend_o        (pend_o),
  .ovf_o         (ovf_o),
  .irq_o         (irq_o),
  .sh_beg        (sh_beg),
  .sh_addr       (sh_addr),
  .irq_en        (irq_en)
);

// File: tb/dma_ch_ctrl_bench.sv
module dma_ch_ctrl_bench;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          reg_we = 0;
  logic [2:0]    reg_sel = 0;
  logic [AW-1:0] reg_wdata = 0;
  logic trig = 0, burst = 0, xstart = 0, word = 0, sync = 0;
  logic ch1 = 0, hcmd = 0, dbg = 0;
  logic [AW-1:0] addr, beg;
  logic pend, ovf, irq, halted;

  dma_ch_ctrl #(.AW(AW), .CW(CW)) u_dma_ch_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .trig_i(trig), .burst_start_i(burst), .xfer_start_i(xstart),
    .word_done_i(word), .sync_err_i(sync),
    .ch1_hi_trig_i(ch1), .halt_cmd_i(hcmd), .dbg_halt_i(dbg),
    .addr_o(addr), .beg_addr_o(beg), .pend_o(pend), .ovf_o(ovf),
    .irq_o(irq), .halted_o(halted)
  );

  int n_chk = 0, n_bad = 0, n_cyc = 0;

  // behavioural reference
  logic [AW-1:0] m_sbeg, m_saddr, m_ws, m_wrs, m_beg, m_addr;
  int            m_len, m_cnt;
  bit            m_en, m_free, m_pend, m_ovf, m_irq;

  function automatic bit m_halt();
    return ch1 || hcmd || (dbg && !m_free);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sbeg = 0; m_saddr = 0; m_ws = 0; m_wrs = 0; m_beg = 0; m_addr = 0;
      m_len = 0; m_cnt = 0; m_en = 0; m_free = 0; m_pend = 0; m_ovf = 0; m_irq = 0;
    end else begin
      bit lost, clr;
      lost = trig && m_pend && !burst;
      clr  = reg_we && reg_sel == 3'd5 && reg_wdata[2];
      m_irq = lost && m_en;
      if (lost) m_ovf = 1; else if (clr) m_ovf = 0;
      if (trig) m_pend = 1; else if (burst) m_pend = 0;
      if (!m_halt()) begin
        if (xstart) begin m_beg = m_sbeg; m_addr = m_saddr; m_cnt = m_len; end
        else if (sync) begin m_addr = m_beg; m_cnt = m_len; end
        else if (word) begin
          if (m_cnt == 0) begin m_beg = m_beg + m_wrs; m_addr = m_beg; m_cnt = m_len; end
          else begin m_addr = m_addr + m_ws; m_cnt = m_cnt - 1; end
        end
      end
      if (reg_we) begin
        case (reg_sel)
          3'd0: m_sbeg = reg_wdata;
          3'd1: m_saddr = reg_wdata;
          3'd2: m_ws = reg_wdata;
          3'd3: m_wrs = reg_wdata;
          3'd4: m_len = int'(reg_wdata[CW-1:0]);
          3'd5: begin m_en = reg_wdata[0]; m_free = reg_wdata[1]; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // compare every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_cyc++;
      chk("R2/R3/R4/R5/R13 addr", addr, m_addr);
      chk("R2/R4/R5/R13 beg", beg, m_beg);
      chk("R7/R9 pend", {31'd0, pend}, {31'd0, m_pend});
      chk("R8/R10 ovf", {31'd0, ovf}, {31'd0, m_ovf});
      chk("R11 irq", {31'd0, irq}, {31'd0, m_irq});
      chk("R12 halted", {31'd0, halted}, {31'd0, m_halt()});
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic idle();
    reg_we = 0; trig = 0; burst = 0; xstart = 0; word = 0; sync = 0;
    ch1 = 0; hcmd = 0; dbg = 0;
  endtask

  task automatic wr(logic [2:0] s, logic [AW-1:0] d);
    reg_we = 1; reg_sel = s; reg_wdata = d; tick(); reg_we = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tick();
    // R1
    chk("R1 addr", addr, 0); chk("R1 beg", beg, 0);
    chk("R1 flags", {28'd0, pend, ovf, irq, halted}, 0);

    wr(3'd0, 32'h1000); wr(3'd1, 32'h1010); wr(3'd2, 32'd4);
    wr(3'd3, 32'h100); wr(3'd4, 32'd2);
    chk("R6 no direct write", addr, 0);

    xstart = 1; tick(); idle();
    chk("R2 start addr", addr, 32'h1010); chk("R2 start beg", beg, 32'h1000);
    word = 1; tick(); tick(); idle();
    chk("R3 step", addr, 32'h1018);
    word = 1; tick(); idle();
    chk("R4 wrap beg", beg, 32'h1100); chk("R4 wrap addr", addr, 32'h1100);

    wr(3'd1, 32'h2000);
    chk("R6 shadow write ignored", addr, 32'h1100);
    word = 1; tick(); idle();
    chk("R3 after wrap", addr, 32'h1104);
    sync = 1; tick(); idle();
    chk("R5 sync addr", addr, 32'h1100); chk("R5 sync beg", beg, 32'h1100);

    hcmd = 1; word = 1; tick();
    chk("R12 cmd halted", {31'd0, halted}, 1);
    chk("R12 cmd freeze", addr, 32'h1100); idle();
    dbg = 1; word = 1; tick();
    chk("R12 dbg halted", {31'd0, halted}, 1);
    chk("R12 dbg freeze", addr, 32'h1100); idle();
    wr(3'd5, 32'h2);
    dbg = 1; word = 1; tick();
    chk("R12 free run", {31'd0, halted}, 0);
    chk("R12 resume", addr, 32'h1104); idle();

    wr(3'd2, 32'hFFFF_FFF8);
    word = 1; tick(); idle();
    chk("R3 negative step", addr, 32'h10FC);

    xstart = 1; sync = 1; word = 1; tick(); idle();
    chk("R13 start wins beg", beg, 32'h1000);
    chk("R13 start wins addr", addr, 32'h2000);
    xstart = 1; tick(); idle();
    chk("R2 shadow kept", beg, 32'h1000);

    trig = 1; tick(); idle();
    chk("R7 set", {31'd0, pend}, 1);
    burst = 1; tick(); idle();
    chk("R7 clear", {31'd0, pend}, 0);
    trig = 1; tick(); tick(); idle();
    chk("R8 ovf", {31'd0, ovf}, 1); chk("R8 pend", {31'd0, pend}, 1);
    chk("R11 irq off", {31'd0, irq}, 0);
    tick();
    chk("R8 sticky", {31'd0, ovf}, 1);
    wr(3'd5, 32'h6);
    chk("R10 clear", {31'd0, ovf}, 0);
    wr(3'd5, 32'h3);
    trig = 1; burst = 1; tick(); idle();
    chk("R9 pend", {31'd0, pend}, 1); chk("R9 no ovf", {31'd0, ovf}, 0);
    trig = 1; tick(); idle();
    chk("R11 irq on", {31'd0, irq}, 1);
    tick();
    chk("R11 pulse", {31'd0, irq}, 0);
    trig = 1; reg_we = 1; reg_sel = 3'd5; reg_wdata = 32'h7; tick(); idle();
    chk("R10 set beats clear", {31'd0, ovf}, 1);

    ch1 = 1; word = 1; tick();
    chk("R12 ch1 halted", {31'd0, halted}, 1);
    chk("R12 ch1 freeze", addr, 32'h2000); idle();
    tick();
    finish_run();
  end
endmodule